// File: doc/BRIEF.md
# Graphics Accelerator Interrupt Unit

This block gathers the interrupt sources of a graphics accelerator on PCI and turns them into one level-sensitive, active-low INTA# line. Four single-cycle event inputs (vertical blank start, drawing engine busy, command FIFO overflow, command FIFO empty) each set a sticky bit in a 4-bit status register. An 8-bit control register enables individual sources. The interrupt is raised while any enabled status bit is set.

Software reaches both registers through byte-wide I/O accesses at two adjacent ports. The status port clears the bits written as one. The odd port above it holds the control byte. The block also answers three locations of PCI configuration space: the command register, the interrupt line and the interrupt pin. A plain read/write strobe interface replaces the PCI target protocol. Read data is combinational and is driven only while the matching read strobe is high.

Top module: `gfx_irq_unit`

## Requirements
- R1: After reset the status and control registers, the PCI command register and the interrupt line register are all 0, and `inta_n_o` is high.
- R2: A pulse on `evt_i[k]` sets status bit k (bit 0 vertical blank, bit 1 engine busy, bit 2 FIFO overflow, bit 3 FIFO empty) at the next clock edge. The bit stays set until software clears it.
- R3: An I/O write to port 0x42E8 clears every status bit whose position holds a 1 in bits 3:0 of the written byte. Bits written as 0 keep their value, and bits 7:4 of the byte have no effect.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: An I/O write to port 0x42E9 loads all 8 bits of the control register. An I/O read of port 0x42E9 returns that byte.
- R6: An I/O read of port 0x42E8 returns the status in bits 3:0, with bits 7:4 reading as 0.
- R7: `inta_n_o` is low exactly when (control bits 3:0 AND status) is nonzero, evaluated one clock after the register values that cause it. Control bits 7:4 never affect the interrupt.
- R8: A configuration write to offset 0x04 stores the byte ANDed with 0x23. A configuration read of offset 0x04 returns the stored value.
- R9: Configuration offset 0x3C is a read/write interrupt line byte. Offset 0x3D always reads 0x01 and ignores writes.
- R10: I/O accesses to any other port and configuration accesses to any other offset change no register and read as 0. Both read buses are 0 while their read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | Single-cycle event pulses, one per status bit |
| io_wr_i | input | 1 | I/O byte write strobe |
| io_rd_i | input | 1 | I/O byte read strobe |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| inta_n_o | output | 1 | Level interrupt, active low |

## Verification
A wrong status or control bit shows up in two places. It appears on `io_rdata_o` in the same cycle as a read of that port. If the bit is enabled, it also appears on `inta_n_o` one clock after the bad value is latched. A lost set-wins priority or a mis-decoded clear appears at the next status read. A bad command mask or a stray configuration write appears at the next configuration read. The bench checks every output on every clock against a behavioural model, so any divergence is reported in the cycle where it first becomes visible at the ports.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  parameter int unsigned EVT_W      = 4;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned IO_ADDR_W  = 16;
  parameter int unsigned CFG_ADDR_W = 8;

  localparam logic [CFG_ADDR_W-1:0] CFG_OFS_CMD  = 8'h04;
  localparam logic [CFG_ADDR_W-1:0] CFG_OFS_LINE = 8'h3C;
  localparam logic [CFG_ADDR_W-1:0] CFG_OFS_PIN  = 8'h3D;
  localparam logic [BYTE_W-1:0]     PIN_INTA     = 8'h01;

  typedef enum logic [1:0] {
    IO_SEL_NONE = 2'd0,
    IO_SEL_STAT = 2'd1,
    IO_SEL_CTRL = 2'd2
  } io_sel_e;
endpackage

// File: rtl/gfx_irq_status.sv
module gfx_irq_status
  import gfx_irq_pkg::*;
#(
  parameter int unsigned W = EVT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        stat_q[i] <= 1'b0;
      else if (set_i[i])                  stat_q[i] <= 1'b1;
      else if (clr_en_i && clr_mask_i[i]) stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  p_set_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && |(set_i & clr_mask_i)) |=> ((stat_q & $past(set_i & clr_mask_i)) != '0));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((stat_q & $past(clr_mask_i & ~set_i)) == '0));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && set_i == '0) |=> $stable(stat_q));
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned SW = EVT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  input  logic [SW-1:0] stat_i,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (ld_i) ctrl_q <= d_i;
  end

  // only the low enable bits gate sources
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(ctrl_q[SW-1:0] & stat_i);
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (ctrl_q == $past(d_i)));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(ctrl_q));
endmodule

// File: rtl/gfx_irq_cfg.sv
module gfx_irq_cfg
  import gfx_irq_pkg::*;
#(
  parameter int unsigned AW       = CFG_ADDR_W,
  parameter int unsigned DW       = BYTE_W,
  parameter logic [DW-1:0] CMD_MASK = 8'h23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cmd_q;
  logic [DW-1:0] line_q;
  logic          hit_cmd, hit_line, hit_pin;

  assign hit_cmd  = (addr_i == CFG_OFS_CMD);
  assign hit_line = (addr_i == CFG_OFS_LINE);
  assign hit_pin  = (addr_i == CFG_OFS_PIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      line_q <= '0;
    end else if (wr_i) begin
      if (hit_cmd)  cmd_q  <= wdata_i & CMD_MASK;
      if (hit_line) line_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_cmd)       rdata_o = cmd_q;
      else if (hit_line) rdata_o = line_q;
      else if (hit_pin)  rdata_o = PIN_INTA;
    end
  end

  p_cmd_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_cmd) |=> (cmd_q == ($past(wdata_i) & CMD_MASK)));
  p_line_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_line) |=> (line_q == $past(wdata_i)));
  p_no_stray_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (hit_cmd || hit_line)) |=> ($stable(cmd_q) && $stable(line_q)));
  p_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_pin) |-> (rdata_o == PIN_INTA));
endmodule

// File: rtl/gfx_irq_unit.sv
module gfx_irq_unit
  import gfx_irq_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] STAT_PORT = 16'h42E8,
  parameter logic [BYTE_W-1:0]    CMD_MASK  = 8'h23
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [EVT_W-1:0]      evt_i,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  input  logic [IO_ADDR_W-1:0]  io_addr_i,
  input  logic [BYTE_W-1:0]     io_wdata_i,
  output logic [BYTE_W-1:0]     io_rdata_o,
  input  logic                  cfg_wr_i,
  input  logic                  cfg_rd_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [BYTE_W-1:0]     cfg_wdata_i,
  output logic [BYTE_W-1:0]     cfg_rdata_o,
  output logic                  inta_n_o
);
  localparam logic [IO_ADDR_W-1:0] CTRL_PORT = STAT_PORT + 1'b1;
  localparam int unsigned PAD_W = BYTE_W - EVT_W;

  io_sel_e           io_sel;
  logic [EVT_W-1:0]  stat_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic              irq_q;

  always_comb begin
    io_sel = IO_SEL_NONE;
    if (io_addr_i == STAT_PORT)      io_sel = IO_SEL_STAT;
    else if (io_addr_i == CTRL_PORT) io_sel = IO_SEL_CTRL;
  end

  gfx_irq_status #(.W(EVT_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_i),
    .clr_en_i   (io_wr_i && io_sel == IO_SEL_STAT),
    .clr_mask_i (io_wdata_i[EVT_W-1:0]),
    .stat_o     (stat_q)
  );

  gfx_irq_ctrl #(.DW(BYTE_W), .SW(EVT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (io_wr_i && io_sel == IO_SEL_CTRL),
    .d_i    (io_wdata_i),
    .stat_i (stat_q),
    .ctrl_o (ctrl_q),
    .irq_o  (irq_q)
  );

  gfx_irq_cfg #(.AW(CFG_ADDR_W), .DW(BYTE_W), .CMD_MASK(CMD_MASK)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .rd_i    (cfg_rd_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      unique case (io_sel)
        IO_SEL_STAT: io_rdata_o = {{PAD_W{1'b0}}, stat_q};
        IO_SEL_CTRL: io_rdata_o = ctrl_q;
        default:     io_rdata_o = '0;
      endcase
    end
  end

  assign inta_n_o = ~irq_q;

  p_inta_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (inta_n_o == !(|($past(ctrl_q[EVT_W-1:0]) & $past(stat_q)))));
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> inta_n_o);
  p_idle_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == '0));
endmodule

// File: tb/gfx_irq_unit_test.sv
module gfx_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       inta_n;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference state
  int m_stat = 0, m_ctrl = 0, m_cmd = 0, m_line = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  gfx_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .inta_n_o(inta_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_io();
    if (!io_rd) return 0;
    if (io_addr == 16'h42E8) return m_stat;
    if (io_addr == 16'h42E9) return m_ctrl;
    return 0;
  endfunction

  function automatic int exp_cfg();
    if (!cfg_rd) return 0;
    case (cfg_addr)
      8'h04:   return m_cmd;
      8'h3C:   return m_line;
      8'h3D:   return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_ctrl = 0; m_cmd = 0; m_line = 0; m_irq = 0;
    end else begin
      m_irq = ((m_ctrl & m_stat & 15) != 0);
      if (io_wr && io_addr == 16'h42E8) m_stat = m_stat & ~(io_wdata & 15);
      m_stat = m_stat | evt;
      if (io_wr && io_addr == 16'h42E9) m_ctrl = io_wdata;
      if (cfg_wr && cfg_addr == 8'h04) m_cmd = cfg_wdata & 8'h23;
      if (cfg_wr && cfg_addr == 8'h3C) m_line = cfg_wdata;
      #2;
      chk("R7", {tag, " inta_n"}, inta_n, !m_irq);
      chk(tag, "io_rdata", io_rdata, exp_io());
      chk(tag, "cfg_rdata", cfg_rdata, exp_cfg());
    end
  end

  task automatic cyc(logic [3:0] e, logic iw, logic ir, logic [15:0] ia, logic [7:0] id,
                     logic cw, logic cr, logic [7:0] ca, logic [7:0] cd);
    @(negedge clk);
    evt = e; io_wr = iw; io_rd = ir; io_addr = ia; io_wdata = id;
    cfg_wr = cw; cfg_rd = cr; cfg_addr = ca; cfg_wdata = cd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(4'h0, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, 8'h0);
  endtask
  task automatic iow(logic [15:0] a, logic [7:0] d); cyc(4'h0, 1, 0, a, d, 0, 0, 8'h0, 8'h0); endtask
  task automatic ior(logic [15:0] a); cyc(4'h0, 0, 1, a, 8'h0, 0, 0, 8'h0, 8'h0); endtask
  task automatic cfw(logic [7:0] a, logic [7:0] d); cyc(4'h0, 0, 0, 16'h0, 8'h0, 1, 0, a, d); endtask
  task automatic cfr(logic [7:0] a); cyc(4'h0, 0, 0, 16'h0, 8'h0, 0, 1, a, 8'h0); endtask
  task automatic ev(logic [3:0] e); cyc(e, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, 8'h0); endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    // R1 reset values at the ports
    tag = "R1";
    #1 chk("R1", "inta_n after reset", inta_n, 1);
    ior(16'h42E8); ior(16'h42E9); cfr(8'h04); cfr(8'h3C); idle(1);

    // R2 each event sets its own bit and sticks
    tag = "R2";
    ev(4'h1); ior(16'h42E8); ev(4'h2); ior(16'h42E8);
    ev(4'h4); ev(4'h8); idle(3); ior(16'h42E8);

    // R3 write-one-to-clear, zeros and upper bits ignored
    tag = "R3";
    iow(16'h42E8, 8'h01); ior(16'h42E8);
    iow(16'h42E8, 8'hF0); ior(16'h42E8);
    iow(16'h42E8, 8'h0F); ior(16'h42E8);

    // R4 set beats clear in the same cycle
    tag = "R4";
    cyc(4'h4, 1, 0, 16'h42E8, 8'h04, 0, 0, 8'h0, 8'h0); ior(16'h42E8);
    cyc(4'h2, 1, 0, 16'h42E8, 8'h0F, 0, 0, 8'h0, 8'h0); ior(16'h42E8);

    // R5 control load and readback
    tag = "R5";
    iow(16'h42E9, 8'hA5); ior(16'h42E9); iow(16'h42E9, 8'h00); ior(16'h42E9);

    // R6 status read shows zero upper nibble
    tag = "R6";
    ev(4'hF); ior(16'h42E8); idle(1);

    // R7 interrupt level with one-cycle lag; upper control bits inert
    tag = "R7";
    iow(16'h42E9, 8'hF0); idle(2);
    iow(16'h42E9, 8'h01); idle(2);
    iow(16'h42E8, 8'h01); idle(2);
    iow(16'h42E9, 8'h08); idle(2);
    iow(16'h42E8, 8'h08); idle(2);
    ev(4'h8); idle(2);
    iow(16'h42E9, 8'h00); idle(2);

    // R8 command register mask
    tag = "R8";
    cfw(8'h04, 8'hFF); cfr(8'h04); cfw(8'h04, 8'hDC); cfr(8'h04);
    cfw(8'h04, 8'h21); cfr(8'h04);

    // R9 interrupt line and pin
    tag = "R9";
    cfw(8'h3C, 8'h0B); cfr(8'h3C); cfw(8'h3D, 8'hFF); cfr(8'h3D);

    // R10 unmapped addresses and idle read buses
    tag = "R10";
    iow(16'h42EA, 8'hFF); iow(16'h42E7, 8'hFF); ior(16'h42EA);
    ior(16'h42E8); ior(16'h42E9);
    cfw(8'h10, 8'hFF); cfw(8'h05, 8'hFF); cfr(8'h10); cfr(8'h05);
    cfr(8'h04); cfr(8'h3C);
    cyc(4'h0, 0, 0, 16'h42E8, 8'h0, 0, 0, 8'h3D, 8'h0);

    // mixed traffic
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [3:0] e;
      logic [15:0] a;
      e = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      a = 16'h42E8 + 16'($urandom % 3);
      cyc(e, 1'($urandom), 1'($urandom), a, 8'($urandom),
          1'($urandom), 1'($urandom), (($urandom % 2) == 0) ? 8'h04 : 8'h3C, 8'($urandom));
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule